// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the configuration port of a display driver chip. A host reaches a small register file over a three-wire serial link made of an active-low chip select, a serial clock and one shared data line. At the pad the shared line is split into an input, an output and an output enable. All three link inputs are synchronised into the system clock domain, and serial clock edges are found there.

A frame begins with a six-bit register address, most significant bit first, and then a direction bit. A write continues with one padding bit and eight data bits. In a read, the eighth clock is a turnaround clock in which no side drives the line. The port then shifts out eight bits of read data.

The register file has four registers:
- a scratch register;
- a fixed identity register;
- a resolution register;
- a power and control-source register.

The block exports a three-bit resolution code and a standby flag. These come either from those registers or from strap pins, depending on a software-control bit.

Top module: `cfg_serial_port`

## Requirements
- R1: A frame starts on the falling edge of `csN`. Bits are sampled on rising `sclk` edges. Bits 0 to 5 are the register address, MSB first. Bit 6 is the direction: 1 means read, 0 means write.
- R2: In a write frame, bit 7 is a padding bit whose value is ignored. Bits 8 to 15 are the write data, MSB first. The addressed register takes this value once bit 15 has been sampled.
- R3: In a read frame, `sdaOe` stays 0 through the eighth clock. From the falling edge that ends it, the port drives read data MSB first and moves to the next bit on each falling edge. The host therefore samples the byte on rising edges 9 to 16.
- R4: Address 0x00 is a scratch register. Every written value reads back unchanged.
- R5: Address 0x01 always reads the parameter `CHIP_ID` (default 0x12: chip identity in the upper nibble, version in the lower nibble). Writes to it are ignored.
- R6: Address 0x02 holds the resolution code in bits 2:0, and its other bits read 0. The legal codes are 7 (800x480), 6 (640x480), 5 (480x272), 4 (480x640), 1 (dual-scan 480x272) and 0 (dual-scan 400x240). A write carrying code 2 or 3 leaves the register unchanged.
- R7: Address 0x03 has two stored bits. Bit 0 is power: 1 means active, 0 means standby. Bit 7 is the software-control bit. Its other bits read 0.
- R8: While bit 7 of 0x03 is 1, `resCode` equals bits 2:0 of 0x02 and `standby` equals the inverse of bit 0 of 0x03. While bit 7 is 0, `resCode` follows `strapRes` and `standby` follows the inverse of `strapActive`.
- R9: If `csN` rises before bit 15 of a write frame has been sampled, no register changes. The next frame decodes from bit 0.
- R10: `sdaOe` is 0 after reset, whenever `csN` is high, and in every write frame.
- R11: While `rstN` is low, every register returns to its default: 0x00 reads 0x00, 0x02 reads 0x07 and 0x03 reads 0x00.
- R12: Addresses 0x04 to 0x3F read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select of the serial link |
| sclk | input | 1 | Serial clock from the host |
| sdaIn | input | 1 | Data line as seen at the pad |
| sdaOut | output | 1 | Data driven onto the line during a read |
| sdaOe | output | 1 | Output enable of the data line pad |
| strapRes | input | 3 | Strap-pin resolution code |
| strapActive | input | 1 | Strap-pin power state, 1 = active |
| resCode | output | 3 | Resolution code exported to the chip |
| standby | output | 1 | Standby state exported to the chip |

## Verification
Some properties are checked on every cycle:
- the resolution field never holds code 2 or 3;
- no register moves except on a write commit;
- a write commits at most once per frame;
- the frame strobes never overlap;
- the pad driver lets go after chip select rises or a drive phase ends.

The scenarios cover what only whole frames can show:
- the bit order of address and data;
- that the turnaround clock stays undriven and read bits appear on the right edges;
- read-back of each register;
- rejection of illegal codes;
- the hand-over of the exported outputs from straps to software;
- aborted frames;
- unmapped addresses;
- reset in the middle of operation.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;

  // Per-cycle strobes from frame control to the register datapath
  typedef struct packed {
    logic shiftIn;      // sample one serial bit
    logic captureHdr;   // address complete, direction bit on the line
    logic commitWrite;  // last write bit on the line
    logic driveFirst;   // start driving read data
    logic driveNext;    // advance to next read bit
    logic dropDrive;    // release the data line
  } ctrlStrb_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= asyncIn;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfgspi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csActive,
  input  logic      sclkRise,
  input  logic      sclkFall,
  input  logic      sdaBit,
  output ctrlStrb_t strb
);

  localparam int FRAME = ADDR_W + 2 + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] DIR_CNT   = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] FIRST_CNT = CNT_W'(ADDR_W + 2);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] END_CNT   = CNT_W'(FRAME);

  logic [CNT_W-1:0] bitCnt;
  logic dirRead;

  always_comb begin
    strb = '0;
    strb.shiftIn     = csActive && sclkRise && (bitCnt < END_CNT);
    strb.captureHdr  = strb.shiftIn && (bitCnt == DIR_CNT);
    strb.commitWrite = strb.shiftIn && (bitCnt == LAST_CNT) && !dirRead;
    strb.driveFirst  = csActive && sclkFall && dirRead && (bitCnt == FIRST_CNT);
    strb.driveNext   = csActive && sclkFall && dirRead &&
                       (bitCnt > FIRST_CNT) && (bitCnt < END_CNT);
    strb.dropDrive   = !csActive || (sclkFall && (!dirRead || bitCnt == END_CNT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      dirRead <= 1'b0;
    end else if (!csActive) begin
      bitCnt  <= '0;
      dirRead <= 1'b0;
    end else if (strb.shiftIn) begin
      bitCnt <= bitCnt + 1'b1;
      if (strb.captureHdr) dirRead <= sdaBit;
    end
  end

  // R2: a write commits at most once per frame
  assert_one_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitWrite |=> !strb.commitWrite);

  // R1: frame strobes never coincide
  assert_strobes_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.captureHdr, strb.commitWrite, strb.driveFirst, strb.driveNext}));

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfgspi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CHIP_ID = 8'h12,
  parameter logic [2:0] RES_DEFAULT = 3'd7
) (
  input  logic      clk,
  input  logic      rstN,
  input  ctrlStrb_t strb,
  input  logic      sdaBit,
  input  logic [2:0] strapRes,
  input  logic      strapActive,
  output logic      sdaOut,
  output logic      sdaOe,
  output logic [2:0] resCode,
  output logic      standby
);

  localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IDENT   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_RES     = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_POWER   = ADDR_W'(3);

  logic [DATA_W-1:0] shiftReg, readBuf, readData, wrData, scratch;
  logic [ADDR_W-1:0] addrReg, hdrAddr;
  logic [2:0] resField;
  logic pwrOn, swSrc;

  assign hdrAddr = shiftReg[ADDR_W-1:0];
  assign wrData  = {shiftReg[DATA_W-2:0], sdaBit};

  always_comb begin
    case (hdrAddr)
      A_SCRATCH: readData = scratch;
      A_IDENT:   readData = CHIP_ID;
      A_RES:     readData = {{(DATA_W-3){1'b0}}, resField};
      A_POWER:   readData = {swSrc, {(DATA_W-2){1'b0}}, pwrOn};
      default:   readData = '0;
    endcase
  end

  // serial input and header capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      addrReg  <= '0;
    end else if (strb.shiftIn) begin
      shiftReg <= wrData;
      if (strb.captureHdr) addrReg <= hdrAddr;
    end
  end

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scratch  <= '0;
      resField <= RES_DEFAULT;
      pwrOn    <= 1'b0;
      swSrc    <= 1'b0;
    end else if (strb.commitWrite) begin
      case (addrReg)
        A_SCRATCH: scratch <= wrData;
        A_RES:     if (wrData[2:1] != 2'b01) resField <= wrData[2:0];
        A_POWER: begin
          pwrOn <= wrData[0];
          swSrc <= wrData[DATA_W-1];
        end
        default: ;
      endcase
    end
  end

  // read-out shifter and pad enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readBuf <= '0;
      sdaOe   <= 1'b0;
    end else begin
      if (strb.captureHdr) readBuf <= readData;
      else if (strb.driveNext) readBuf <= {readBuf[DATA_W-2:0], 1'b0};
      if (strb.dropDrive) sdaOe <= 1'b0;
      else if (strb.driveFirst) sdaOe <= 1'b1;
    end
  end

  assign sdaOut  = readBuf[DATA_W-1];
  assign resCode = swSrc ? resField : strapRes;
  assign standby = swSrc ? ~pwrOn : ~strapActive;

  // R6: illegal resolution codes never stored
  assert_res_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    resField[2:1] != 2'b01);

  // R9: registers move only on a write commit
  assert_hold_no_commit_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitWrite |=> $stable({scratch, resField, pwrOn, swSrc}));

  // R3: drive released once a drive phase ends
  assert_drop_drive_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.dropDrive |=> !sdaOe);

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgspi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CHIP_ID = 8'h12,
  parameter logic [2:0] RES_DEFAULT = 3'd7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdaIn,
  output logic       sdaOut,
  output logic       sdaOe,
  input  logic [2:0] strapRes,
  input  logic       strapActive,
  output logic [2:0] resCode,
  output logic       standby
);

  logic [2:0] syncd;
  logic csS, sclkS, sdaS, sclkPrev;
  ctrlStrb_t strb;

  cfg_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn({csN, sclk, sdaIn}), .syncOut(syncd)
  );
  assign {csS, sclkS, sdaS} = syncd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else sclkPrev <= sclkS;
  end

  cfg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csActive(!csS),
    .sclkRise(sclkS && !sclkPrev), .sclkFall(!sclkS && sclkPrev),
    .sdaBit(sdaS), .strb(strb)
  );

  cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHIP_ID(CHIP_ID),
             .RES_DEFAULT(RES_DEFAULT)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaS),
    .strapRes(strapRes), .strapActive(strapActive),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .resCode(resCode), .standby(standby)
  );

  // R10: pad never driven once chip select is seen high
  assert_idle_no_drive_R10: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> !sdaOe);

endmodule

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;

  logic clk = 1'b0;
  logic rstN, csN, sclk, sdaIn, strapActive;
  logic [2:0] strapRes;
  logic sdaOut, sdaOe, standby;
  logic [2:0] resCode;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  cfg_serial_port dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdaIn(sdaIn),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .strapRes(strapRes),
    .strapActive(strapActive), .resCode(resCode), .standby(standby)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // driver: one frame, optionally cut short after stopAfter bits
  task automatic xfer(input bit isRead, input logic [5:0] addr,
                      input logic [7:0] data, input int stopAfter = 16);
    logic [15:0] frame;
    frame = {addr, isRead, ~isRead, isRead ? 8'h00 : data};
    csN = 1'b0;
    #80;
    for (int i = 0; i < 16 && i < stopAfter; i++) begin
      sdaIn = frame[15-i];
      #80 sclk = 1'b1;
      #80 sclk = 1'b0;
    end
    #80 csN = 1'b1;
    #160;
  endtask

  task automatic readExp(input logic [5:0] addr, input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    xfer(1'b1, addr, 8'h00);
  endtask

  // monitor: decodes frames on the line and compares read bytes
  initial begin : monitor
    int rises;
    bit rd, oeAll;
    logic [7:0] byteV;
    forever begin
      @(negedge csN);
      rises = 0; rd = 0; oeAll = 1; byteV = '0;
      forever begin
        @(posedge sclk or posedge csN);
        if (csN) break;
        rises++;
        if (rises == 7) rd = sdaIn;
        if (!rd && rises >= 8) check("R10 no drive in write frame", {7'd0, sdaOe}, 8'd0);
        if (rd && rises == 8) check("R3 turnaround undriven", {7'd0, sdaOe}, 8'd0);
        if (rd && rises >= 9 && rises <= 16) begin
          byteV = {byteV[6:0], sdaOut};
          oeAll &= sdaOe;
        end
        if (rd && rises == 16) begin
          if (expQ.size() == 0) check("R3 unexpected read", 8'd1, 8'd0);
          else check(tagQ.pop_front(), byteV, expQ.pop_front());
          check("R3 driven during data", {7'd0, oeAll}, 8'd1);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdaIn = 1'b0;
    strapRes = 3'd5; strapActive = 1'b1;
    #42 rstN = 1'b1;
    #80;
    check("R10 oe after reset", {7'd0, sdaOe}, 8'd0);
    check("R8 hw res after reset", {5'd0, resCode}, 8'd5);
    check("R8 hw standby after reset", {7'd0, standby}, 8'd0);

    readExp(6'h00, 8'h00, "R11 scratch default");
    readExp(6'h01, 8'h12, "R5 identity");
    readExp(6'h02, 8'h07, "R11 res default");
    readExp(6'h03, 8'h00, "R7 power default");

    xfer(1'b0, 6'h00, 8'h55);
    readExp(6'h00, 8'h55, "R4 scratch 0x55");
    xfer(1'b0, 6'h00, 8'hA3);
    readExp(6'h00, 8'hA3, "R2 R1 bit order 0xA3");

    xfer(1'b0, 6'h01, 8'hFF);
    readExp(6'h01, 8'h12, "R5 identity write ignored");

    xfer(1'b0, 6'h02, 8'hFE);
    readExp(6'h02, 8'h06, "R6 code 6 upper bits dropped");
    xfer(1'b0, 6'h02, 8'h03);
    readExp(6'h02, 8'h06, "R6 code 3 rejected");
    xfer(1'b0, 6'h02, 8'h02);
    readExp(6'h02, 8'h06, "R6 code 2 rejected");
    check("R8 strap res while hw", {5'd0, resCode}, 8'd5);

    strapRes = 3'd4; strapActive = 1'b0;
    #80;
    check("R8 strap res follows", {5'd0, resCode}, 8'd4);
    check("R8 strap standby follows", {7'd0, standby}, 8'd1);

    xfer(1'b0, 6'h03, 8'h81);
    readExp(6'h03, 8'h81, "R7 power 0x81");
    check("R8 sw res", {5'd0, resCode}, 8'd6);
    check("R8 sw standby active", {7'd0, standby}, 8'd0);
    xfer(1'b0, 6'h03, 8'h80);
    check("R8 sw standby set", {7'd0, standby}, 8'd1);
    xfer(1'b0, 6'h03, 8'hFF);
    readExp(6'h03, 8'h81, "R7 unused bits read 0");

    xfer(1'b0, 6'h00, 8'h3C, 12);
    readExp(6'h00, 8'hA3, "R9 aborted write no update");
    xfer(1'b0, 6'h00, 8'h3C, 15);
    readExp(6'h00, 8'hA3, "R9 abort at bit 15 no update");
    xfer(1'b1, 6'h01, 8'h00, 11);
    readExp(6'h00, 8'hA3, "R9 frame after aborted read");

    xfer(1'b0, 6'h20, 8'hFF);
    readExp(6'h20, 8'h00, "R12 unmapped address");
    readExp(6'h00, 8'hA3, "R12 unmapped write no alias");

    rstN = 1'b0;
    #16 rstN = 1'b1;
    #80;
    check("R11 res export after reset", {5'd0, resCode}, 8'd4);
    readExp(6'h03, 8'h00, "R11 power reset");
    readExp(6'h00, 8'h00, "R11 scratch reset");

    check("R3 scoreboard drained", 8'(expQ.size()), 8'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule